// File: doc/BRIEF.md
# Multilevel Cell Program-Verify Sequencer

This block stores a 2-bit value in one resistive multilevel memory cell. It steers a write driver through a current-DAC code, a pulse strobe and a pulse-shape select, and it reads back a digitised log-resistance value from a sense path. The two extreme codes need one fixed pulse each. Code `11` is the low-resistance crystalline level and takes a SET-shaped pulse. Code `00` is the high-resistance amorphous level and takes a strong RESET pulse. The two intermediate codes start with the same fixed SET-shaped pulse. A staircase of RESET pulses follows, and the first step is at a programmable start current. Each later pulse is one programmable increment higher than the one before. After every pulse the block waits a settle interval and then takes a verify read.

The verify read is compared against a resistance window that belongs to the target code. The sequence ends with success when the reading lands inside the window. It ends with failure when the reading is above the window, when the pulse budget is spent, or when the next current step would pass full scale. The block reports the number of RESET pulses it used. A caller raises `start_i` for one cycle while the block is idle and then waits for `done_o`. The caller can pick the start current for each target code, which cuts the number of pulses.

Top module: `mlc_pv_ctrl`

## Requirements
- R1: After reset, and whenever idle, `busy_o`, `pulse_o`, `set_mode_o`, `sense_req_o`, `done_o` and `fail_o` are low and `dac_code_o` is 0. `pulse_cnt_o` is 0 after reset.
- R2: Code `11` produces a single SET-shaped pulse (`set_mode_o`=1) of FIX_PW (8) cycles at DAC code OSET_CODE (200), followed by `done_o` with no fail and no verify read.
- R3: Code `00` produces a single RESET pulse (`set_mode_o`=0) of FIX_PW cycles at DAC code ORST_CODE (1000), followed by `done_o` with no fail and no verify read.
- R4: Codes `10` and `01` first issue the same SET-shaped pulse as R2. They then issue RESET pulses of `pw_i` cycles each (0 counts as 1). The first RESET pulse is at `istart_i`, and each following one is `istep_i` higher (1 LSB = 1 uA). `dac_code_o` is 0 whenever `pulse_o` is low.
- R5: Each RESET pulse is followed by SETTLE_CYC (4) quiet cycles. `sense_req_o` then rises and stays high until a cycle with `sense_valid_i` high. `sense_res_i` is used only in that cycle.
- R6: The sense code is 32 times log10 of the resistance. The window for code `10` is [160,176) and the window for code `01` is [176,192). A reading inside the window ends the sequence with `done_o` and no fail.
- R7: A reading at or above the upper bound of the window ends the sequence with `done_o` and `fail_o`.
- R8: A reading below the window after the pulse that brings the count to `limit_i` ends with failure. A `limit_i` of 0 selects 64.
- R9: A reading below the window ends with failure when the current after one more step would exceed 1023.
- R10: A reading inside the window wins over the pulse limit and over saturation when they fall on the same verify.
- R11: `pulse_cnt_o` clears when a start is accepted, rises by one as each RESET pulse begins, and holds its value after `done_o`.
- R12: `start_i` and every operand input are ignored while `busy_o` is high, including the `done_o` cycle.
- R13: `done_o` lasts one cycle, and `busy_o` is low in the next cycle. `fail_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to write one cell |
| level_i | input | 2 | Target 2-bit code |
| istart_i | input | 10 | First RESET current code |
| istep_i | input | 10 | Current increment per RESET pulse |
| pw_i | input | 8 | RESET pulse width in cycles |
| limit_i | input | 8 | Maximum RESET pulses, 0 selects 64 |
| sense_valid_i | input | 1 | Sense result strobe |
| sense_res_i | input | 8 | Log-resistance code, 32 per decade |
| dac_code_o | output | 10 | Write-driver current code |
| pulse_o | output | 1 | Pulse enable to the driver |
| set_mode_o | output | 1 | 1 = SET-shaped pulse, 0 = RESET pulse |
| sense_req_o | output | 1 | Verify read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion flag |
| fail_o | output | 1 | Completion was unsuccessful |
| pulse_cnt_o | output | 8 | RESET pulses used |

## Verification
Two pairs of events can land in the same cycle. The first pair is a verify result inside the window together with the last pulse allowed by the limit, or together with a current step that would saturate. The bench sets the limit, or a start current near full scale, so that the window is reached on exactly that verify, and it expects success with the matching pulse count. The second pair is a new start request together with the `done_o` cycle. The bench raises `start_i` with different operands in that cycle and also in the middle of the operation, and the reference trace requires both requests to leave the outputs unchanged.

// File: rtl/mlc_pv_pkg.sv
package mlc_pv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_RPULSE, ST_SETTLE, ST_VERIFY, ST_FIN
  } pv_state_e;

  typedef enum logic [1:0] {CMP_BELOW, CMP_INSIDE, CMP_ABOVE} cmp_e;

  localparam logic [1:0] LVL_LOW_R  = 2'b11;
  localparam logic [1:0] LVL_HIGH_R = 2'b00;
  localparam logic [1:0] LVL_MID_LO = 2'b10;
  localparam logic [1:0] LVL_MID_HI = 2'b01;
endpackage

// File: rtl/mlc_pv_timer.sv
module mlc_pv_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mlc_pv_window.sv
module mlc_pv_window import mlc_pv_pkg::*; #(
  parameter int RES_W     = 8,
  parameter int RES_SCALE = 32
) (
  input  logic [1:0]       level_i,
  input  logic [RES_W-1:0] res_i,
  output cmp_e             cmp_o
);
  localparam int LO  = 5 * RES_SCALE;
  localparam int MID = 5 * RES_SCALE + RES_SCALE / 2;
  localparam int HI  = 6 * RES_SCALE;

  logic [RES_W-1:0] lo_b, hi_b;

  always_comb begin
    unique case (level_i)
      LVL_MID_LO: begin lo_b = RES_W'(LO);  hi_b = RES_W'(MID); end
      LVL_MID_HI: begin lo_b = RES_W'(MID); hi_b = RES_W'(HI);  end
      default:    begin lo_b = RES_W'(LO);  hi_b = RES_W'(HI);  end
    endcase
    if (res_i < lo_b)       cmp_o = CMP_BELOW;
    else if (res_i >= hi_b) cmp_o = CMP_ABOVE;
    else                    cmp_o = CMP_INSIDE;
  end
endmodule

// File: rtl/mlc_pv_seq.sv
module mlc_pv_seq import mlc_pv_pkg::*; #(
  parameter int DAC_W      = 10,
  parameter int PW_W       = 8,
  parameter int CNT_W      = 8,
  parameter int DEF_LIMIT  = 64,
  parameter int SETTLE_CYC = 4,
  parameter int FIX_PW     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       level_i,
  input  logic [DAC_W-1:0] istart_i,
  input  logic [DAC_W-1:0] istep_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             sense_valid_i,
  input  cmp_e             cmp_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [PW_W-1:0]  tmr_val_o,
  output pv_state_e        state_o,
  output logic [1:0]       level_o,
  output logic [DAC_W-1:0] cur_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fail_o
);
  localparam logic [PW_W-1:0]  FIX_LD    = PW_W'(FIX_PW - 1);
  localparam logic [PW_W-1:0]  SETTLE_LD = PW_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] DEF_LIM   = CNT_W'(DEF_LIMIT);

  pv_state_e        state_q, state_d;
  logic [1:0]       lvl_q;
  logic [DAC_W-1:0] step_q, cur_q, cur_d;
  logic [PW_W-1:0]  pw_q;
  logic [CNT_W-1:0] lim_q, cnt_q, cnt_d;
  logic             fail_q, fail_d, latch;
  logic [DAC_W:0]   nxt_sum;
  logic [PW_W-1:0]  pw_ld;
  logic [CNT_W-1:0] lim_eff;
  logic             extreme;

  assign nxt_sum = {1'b0, cur_q} + {1'b0, step_q};
  assign pw_ld   = (pw_q == '0) ? '0 : pw_q - 1'b1;
  assign lim_eff = (lim_q == '0) ? DEF_LIM : lim_q;
  assign extreme = (lvl_q == LVL_LOW_R) || (lvl_q == LVL_HIGH_R);

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cur_d      = cur_q;
    cnt_d      = cnt_q;
    fail_d     = fail_q;
    latch      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_INIT; tmr_load_o = 1'b1; tmr_val_o = FIX_LD;
        latch = 1'b1; cnt_d = '0; fail_d = 1'b0; cur_d = istart_i;
      end
      ST_INIT: if (tmr_exp_i) begin
        if (extreme) state_d = ST_FIN;
        else begin
          state_d = ST_RPULSE; tmr_load_o = 1'b1; tmr_val_o = pw_ld;
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RPULSE: if (tmr_exp_i) begin
        state_d = ST_SETTLE; tmr_load_o = 1'b1; tmr_val_o = SETTLE_LD;
      end
      ST_SETTLE: if (tmr_exp_i) state_d = ST_VERIFY;
      ST_VERIFY: if (sense_valid_i) begin
        unique case (cmp_i)
          CMP_INSIDE: state_d = ST_FIN;
          CMP_ABOVE:  begin state_d = ST_FIN; fail_d = 1'b1; end
          default: begin
            if (cnt_q >= lim_eff || nxt_sum[DAC_W]) begin
              state_d = ST_FIN; fail_d = 1'b1;
            end else begin
              state_d = ST_RPULSE; tmr_load_o = 1'b1; tmr_val_o = pw_ld;
              cur_d = nxt_sum[DAC_W-1:0]; cnt_d = cnt_q + 1'b1;
            end
          end
        endcase
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      step_q  <= '0;
      pw_q    <= '0;
      lim_q   <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      fail_q  <= fail_d;
      if (latch) begin
        lvl_q  <= level_i;
        step_q <= istep_i;
        pw_q   <= pw_i;
        lim_q  <= limit_i;
      end
    end
  end

  assign state_o = state_q;
  assign level_o = lvl_q;
  assign cur_o   = cur_q;
  assign cnt_o   = cnt_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/mlc_pv_ctrl.sv
module mlc_pv_ctrl import mlc_pv_pkg::*; #(
  parameter int DAC_W      = 10,
  parameter int RES_W      = 8,
  parameter int PW_W       = 8,
  parameter int CNT_W      = 8,
  parameter int RES_SCALE  = 32,
  parameter int DEF_LIMIT  = 64,
  parameter int SETTLE_CYC = 4,
  parameter int FIX_PW     = 8,
  parameter int OSET_CODE  = 200,
  parameter int ORST_CODE  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       level_i,
  input  logic [DAC_W-1:0] istart_i,
  input  logic [DAC_W-1:0] istep_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             sense_valid_i,
  input  logic [RES_W-1:0] sense_res_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             pulse_o,
  output logic             set_mode_o,
  output logic             sense_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pulse_cnt_o
);
  pv_state_e        state;
  cmp_e             cmp;
  logic [1:0]       lvl;
  logic [DAC_W-1:0] cur;
  logic             tmr_load, tmr_exp, fail_flag;
  logic [PW_W-1:0]  tmr_val;

  mlc_pv_seq #(
    .DAC_W(DAC_W), .PW_W(PW_W), .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT),
    .SETTLE_CYC(SETTLE_CYC), .FIX_PW(FIX_PW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .level_i, .istart_i, .istep_i, .pw_i,
    .limit_i, .sense_valid_i,
    .cmp_i(cmp), .tmr_exp_i(tmr_exp), .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val), .state_o(state), .level_o(lvl), .cur_o(cur),
    .cnt_o(pulse_cnt_o), .fail_o(fail_flag)
  );

  mlc_pv_timer #(.CW(PW_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  mlc_pv_window #(.RES_W(RES_W), .RES_SCALE(RES_SCALE)) u_win (
    .level_i(lvl), .res_i(sense_res_i), .cmp_o(cmp)
  );

  always_comb begin
    unique case (state)
      ST_INIT:   dac_code_o = (lvl == LVL_HIGH_R) ? DAC_W'(ORST_CODE) : DAC_W'(OSET_CODE);
      ST_RPULSE: dac_code_o = cur;
      default:   dac_code_o = '0;
    endcase
  end

  assign pulse_o     = (state == ST_INIT) || (state == ST_RPULSE);
  assign set_mode_o  = (state == ST_INIT) && (lvl != LVL_HIGH_R);
  assign sense_req_o = (state == ST_VERIFY);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FIN);
  assign fail_o      = done_o && fail_flag;
endmodule

// File: rtl/mlc_pv_ctrl_chk.sv
module mlc_pv_ctrl_chk #(
  parameter int DAC_W = 10,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             sense_valid_i,
  input logic [DAC_W-1:0] dac_code_o,
  input logic             pulse_o,
  input logic             set_mode_o,
  input logic             sense_req_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] pulse_cnt_o
);
  AST_FAIL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o); // R13
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R13
  AST_DAC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> dac_code_o == '0); // R4
  AST_NO_SENSE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !sense_req_o); // R5
  AST_SENSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_req_o && !sense_valid_i |=> sense_req_o); // R5
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && pulse_o && pulse_cnt_o == '0); // R11
  AST_CNT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(pulse_cnt_o)); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> pulse_cnt_o == $past(pulse_cnt_o) || pulse_cnt_o == $past(pulse_cnt_o) + 1'b1); // R11
  AST_SET_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_o |-> pulse_o); // R2
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !pulse_o |=> !$rose(pulse_o) || pulse_cnt_o != '0); // R12
endmodule

bind mlc_pv_ctrl mlc_pv_ctrl_chk #(.DAC_W(DAC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sense_valid_i(sense_valid_i),
  .dac_code_o(dac_code_o), .pulse_o(pulse_o), .set_mode_o(set_mode_o),
  .sense_req_o(sense_req_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .pulse_cnt_o(pulse_cnt_o)
);

// File: tb/mlc_pv_ctrl_bench.sv
module mlc_pv_ctrl_bench;
  localparam int FIXW = 8;
  localparam int SETL = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, sv, pulse, setm, sreq, busy, done, fail;
  logic [1:0] level;
  logic [9:0] istart, istep, dac;
  logic [7:0] pw, limit, sres, pcnt;

  mlc_pv_ctrl u_mlc_pv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .level_i(level),
    .istart_i(istart), .istep_i(istep), .pw_i(pw), .limit_i(limit),
    .sense_valid_i(sv), .sense_res_i(sres), .dac_code_o(dac), .pulse_o(pulse),
    .set_mode_o(setm), .sense_req_o(sreq), .busy_o(busy), .done_o(done),
    .fail_o(fail), .pulse_cnt_o(pcnt)
  );

  typedef struct packed {
    logic pulse; logic setm; logic [9:0] dac; logic sreq;
    logic busy; logic done; logic fail; logic [7:0] cnt;
  } exp_t;

  exp_t  exq[$];
  string tgq[$];
  int vecs = 0, errs = 0, last_cnt = 0, cyc = 0;
  int div = 2, lat = 2, cell_res = 100, scnt = 0, decoy = 165;

  function automatic int res_of(int c, int d);
    int r;
    if (c <= 300) return 100;
    r = 100 + (c - 300) / d;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic void push(logic p, logic s, int dv, logic sr, logic dn,
                               logic fl, int cn, string tg);
    exp_t e;
    e = '{p, s, 10'(dv), sr, 1'b1, dn, fl, 8'(cn)};
    exq.push_back(e);
    tgq.push_back(tg);
  endfunction

  // behavioural reference: expected per-cycle trace of one operation
  function automatic void plan(int lv, int ist, int stp, int pwi, int lim,
                               int d, int la, string ov);
    int cur, n, r, lo, hi, pwe, lime;
    string tg;
    tg = (lv == 3) ? "R2" : (lv == 0) ? "R3" : "R4";
    if (ov != "") tg = ov;
    for (int i = 0; i < FIXW; i++)
      push(1'b1, lv != 0, (lv == 0) ? 1000 : 200, 1'b0, 1'b0, 1'b0, 0, tg);
    if (lv == 3 || lv == 0) begin
      push(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0, 0, (ov != "") ? ov : "R13 R11");
      last_cnt = 0;
      return;
    end
    lo = (lv == 2) ? 160 : 176;
    hi = (lv == 2) ? 176 : 192;
    pwe = (pwi == 0) ? 1 : pwi;
    lime = (lim == 0) ? 64 : lim;
    cur = ist; n = 0;
    forever begin
      n++;
      for (int i = 0; i < pwe; i++)
        push(1'b1, 1'b0, cur, 1'b0, 1'b0, 1'b0, n, (ov != "") ? ov : "R4");
      for (int i = 0; i < SETL; i++)
        push(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, n, (ov != "") ? ov : "R5");
      for (int i = 0; i < la; i++)
        push(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, n, (ov != "") ? ov : "R5");
      r = res_of(cur, d);
      if (r >= lo && r < hi) begin
        push(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0, n,
             (ov != "") ? ov : (n >= lime || cur + stp > 1023) ? "R10" : "R6 R11");
        break;
      end else if (r >= hi) begin
        push(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b1, n, (ov != "") ? ov : "R7");
        break;
      end else if (n >= lime) begin
        push(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b1, n, (ov != "") ? ov : "R8");
        break;
      end else if (cur + stp > 1023) begin
        push(1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b1, n, (ov != "") ? ov : "R9");
        break;
      end
      cur += stp;
    end
    last_cnt = n;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    exp_t e, a;
    string t;
    if (exq.size() > 0) begin
      e = exq.pop_front();
      t = tgq.pop_front();
    end else begin
      e = '{1'b0, 1'b0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'(last_cnt)};
      t = "R1";
    end
    a = '{pulse, setm, dac, sreq, busy, done, fail, pcnt};
    vecs++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s t=%0t act p=%b s=%b dac=%0d sr=%b b=%b d=%b f=%b n=%0d exp p=%b s=%b dac=%0d sr=%b b=%b d=%b f=%b n=%0d",
               t, $time, a.pulse, a.setm, a.dac, a.sreq, a.busy, a.done, a.fail, a.cnt,
               e.pulse, e.setm, e.dac, e.sreq, e.busy, e.done, e.fail, e.cnt);
    end
  end

  // cell and sense-path model
  always @(negedge clk) begin
    if (pulse) cell_res = setm ? 100 : res_of(int'(dac), div);
    if (sreq) begin
      scnt++;
      sv   = (scnt == lat);
      sres = sv ? 8'(cell_res) : 8'(decoy);
    end else begin
      scnt = 0;
      sv   = 1'b0;
      sres = 8'(decoy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic run_op(int lv, int ist, int stp, int pwi, int lim, int d,
                        int la, bit poke, string ov);
    int f;
    @(negedge clk); #1;
    div = d; lat = la; decoy = (lv == 1) ? 180 : 165;
    level = 2'(lv); istart = 10'(ist); istep = 10'(stp);
    pw = 8'(pwi); limit = 8'(lim); start = 1'b1;
    plan(lv, ist, stp, pwi, lim, d, la, ov);
    f = exq.size() - 1;
    for (int m = 0; m <= f + 1; m++) begin
      @(negedge clk); #1;
      if (poke && (m == 2 || m == f)) begin
        start = 1'b1; level = 2'b11; istart = 10'd7; pw = 8'd1; limit = 8'd1;
      end else begin
        start = 1'b0; level = 2'(lv); istart = 10'(ist); pw = 8'(pwi); limit = 8'(lim);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; level = '0; istart = '0; istep = '0;
    pw = '0; limit = '0; sv = 1'b0; sres = '0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(3, 400, 10, 3, 0, 2, 2, 1'b0, "");        // R2
    run_op(0, 400, 10, 3, 0, 2, 2, 1'b0, "");        // R3
    run_op(2, 400, 10, 3, 0, 2, 2, 1'b0, "");        // R4 R6: three steps
    run_op(1, 400, 20, 6, 0, 2, 5, 1'b0, "");        // R4 R5: longer sense latency
    run_op(2, 360, 10, 0, 0, 1, 1, 1'b0, "");        // R6 lower bound, pw 0 -> 1
    run_op(2, 376, 10, 2, 0, 1, 2, 1'b0, "");        // R7 reading at upper bound
    run_op(1, 376, 10, 2, 0, 1, 2, 1'b0, "");        // R6 code 01 lower bound
    run_op(1, 300, 1, 1, 0, 100, 1, 1'b0, "");       // R8 default limit 64
    run_op(2, 400, 10, 2, 3, 2, 2, 1'b0, "");        // R10 window on limit pulse
    run_op(2, 400, 10, 2, 2, 2, 2, 1'b0, "");        // R8 limit 2
    run_op(2, 1000, 20, 2, 0, 255, 2, 1'b0, "");     // R9 saturation
    run_op(2, 1010, 20, 2, 0, 10, 2, 1'b0, "");      // R10 window beats saturation
    run_op(2, 400, 10, 3, 0, 2, 2, 1'b1, "R12");     // R12 start while busy and on done
    run_op(3, 400, 10, 3, 0, 2, 2, 1'b1, "R12");     // R12 extreme code
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule